// File: doc/BRIEF.md
# Translation Unit Command and Status Controller

This block is the register face of an address translation unit. Software reaches it through a simple word-wide register port. It uses the port to point the unit at its first-level table, to turn translation on and off, to hold traffic in a stall, and to flush cached translations. It can also return the unit to its power-on state. The table walker sits beside the block and reports page faults and bus read errors into it. The block records the fault details, keeps a per-cause pending word and raises one interrupt line through a mask.

Commands are issued by writing a small code to the command register. The block applies each one in the cycle after the write. A stall request is refused unless translation is enabled and no fault is outstanding. Invalidate requests reach the translation cache as one-cycle pulses on dedicated outputs.

Top module: `xlat_ctrl`

Register byte offsets on `busAddr`:

- 0x00: table base
- 0x04: status
- 0x08: command
- 0x0C: fault address
- 0x10: single-line invalidate
- 0x14: raw pending
- 0x18: pending clear
- 0x1C: interrupt mask
- 0x20: masked pending
- 0x24: gating configuration

The write-only registers read as zero.

## Requirements
- R1: After reset the table base, mask, pending word and gating register read 0, `irq` is 0, and status (offset 0x04) reads 0x8000_0018 when `walkBusy`=0 and `replayEmpty`=1.
- R2: A write to the table base (0x00) stores only bits 31:12, with the low 12 bits reading 0; writing 0xCAFEBABE reads back 0xCAFEB000.
- R3: Command code 0 written to offset 0x08 sets status bit 0 and `pagingOn`; code 1 clears them.
- R4: Command code 2 sets the stall state (status bit 2, `stallOn`) only when translation is enabled and no fault is active; code 3 clears it. Status bit 31 always reads as the inverse of bit 2.
- R5: When `faultPulse` arrives with no fault active, the block sets status bit 1 and pending bit 0. It captures `faultAddr` (read at 0x0C), the access direction (status bit 5, 1 = write) and `faultMaster` (status bits 10:6). A fault arriving while one is active still sets pending bit 0 but does not overwrite the captured details.
- R6: Command code 5 clears the fault-active state (status bit 1).
- R7: `busErrPulse` sets pending bit 1. Offset 0x20 reads the pending word AND the mask (0x1C, bits 1:0). `irq` is the OR of the masked bits.
- R8: Writing ones to offset 0x18 clears the matching pending bits. A new event arriving in the same cycle as the clear wins.
- R9: Command code 4 pulses `zapAll` for exactly one cycle. A write to 0x10 pulses `zapLine` for one cycle, with `zapLineAddr` equal to the written value with bits 11:0 cleared.
- R10: Command code 6 returns the table base, paging, stall, fault state, pending word, mask and gating register to zero.
- R11: Status bit 3 (idle) reads 1 exactly when `walkBusy` is 0 and no fault is active.
- R12: Command values of 7 or above leave all state unchanged. The gating register (0x24) reads back what was written and drives `gateCfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 6 | Register byte offset for write and read |
| busWrData | input | 32 | Register write data |
| rdData | output | 32 | Read data for busAddr (combinational) |
| walkBusy | input | 1 | A translation request is in flight |
| replayEmpty | input | 1 | Replay buffer empty, reported in status bit 4 |
| faultPulse | input | 1 | Walker page-fault event |
| faultAddr | input | 32 | Faulting virtual address |
| faultIsWrite | input | 1 | Faulting access was a write |
| faultMaster | input | 5 | Bus master ID of the faulting access |
| busErrPulse | input | 1 | Walker bus read error event |
| irq | output | 1 | Interrupt request |
| pagingOn | output | 1 | Translation enabled |
| stallOn | output | 1 | Stall state active |
| zapAll | output | 1 | One-cycle full invalidate pulse |
| zapLine | output | 1 | One-cycle single-line invalidate pulse |
| zapLineAddr | output | 32 | Page-aligned address for zapLine |
| gateCfg | output | 32 | Gating configuration value |

## Verification
The bench asks for a stall twice where it must be refused: once with translation off and once while a fault is active. A design that skips either gate would report stall active and drop bit 31. It sends a second fault while the first is still active. A design that re-captures would then show the second address. It sends a bus error in the same cycle as a clear of that bit. A design that lets the clear win loses the event. It also checks that hard reset zeroes the table base and the mask, and that command values above 6 are ignored, including a code hidden in the upper bits.

// File: rtl/xlat_ctrl_pkg.sv
package xlat_ctrl_pkg;
  localparam int OFS_BASE   = 'h00;
  localparam int OFS_STATUS = 'h04;
  localparam int OFS_CMD    = 'h08;
  localparam int OFS_FADDR  = 'h0C;
  localparam int OFS_ZLINE  = 'h10;
  localparam int OFS_RAW    = 'h14;
  localparam int OFS_CLEAR  = 'h18;
  localparam int OFS_MASK   = 'h1C;
  localparam int OFS_MSKD   = 'h20;
  localparam int OFS_GATE   = 'h24;

  typedef enum logic [2:0] {
    CMD_PAGE_ON   = 3'd0,
    CMD_PAGE_OFF  = 3'd1,
    CMD_STALL_ON  = 3'd2,
    CMD_STALL_OFF = 3'd3,
    CMD_ZAP_ALL   = 3'd4,
    CMD_FAULT_ACK = 3'd5,
    CMD_HARD_RST  = 3'd6
  } cmdCode_e;

  typedef struct packed {
    logic wrBase;
    logic wrMask;
    logic wrGate;
    logic wrClear;
    logic zapOne;
    logic pageOn;
    logic pageOff;
    logic stallOn;
    logic stallOff;
    logic zapAll;
    logic faultDone;
    logic hardRst;
  } ctlStrobe_t;
endpackage

// File: rtl/xlat_ctrl_ctl.sv
module xlat_ctrl_ctl
  import xlat_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output ctlStrobe_t        strb
);
  localparam int CODE_W = 3;

  logic cmdWr;
  logic codeInRange;

  assign cmdWr       = busWrEn && (busAddr == ADDR_W'(OFS_CMD));
  assign codeInRange = (busWrData[DATA_W-1:CODE_W] == '0);

  always_comb begin
    strb         = '0;
    strb.wrBase  = busWrEn && (busAddr == ADDR_W'(OFS_BASE));
    strb.wrMask  = busWrEn && (busAddr == ADDR_W'(OFS_MASK));
    strb.wrGate  = busWrEn && (busAddr == ADDR_W'(OFS_GATE));
    strb.wrClear = busWrEn && (busAddr == ADDR_W'(OFS_CLEAR));
    strb.zapOne  = busWrEn && (busAddr == ADDR_W'(OFS_ZLINE));
    if (cmdWr && codeInRange) begin
      case (cmdCode_e'(busWrData[CODE_W-1:0]))
        CMD_PAGE_ON:   strb.pageOn    = 1'b1;
        CMD_PAGE_OFF:  strb.pageOff   = 1'b1;
        CMD_STALL_ON:  strb.stallOn   = 1'b1;
        CMD_STALL_OFF: strb.stallOff  = 1'b1;
        CMD_ZAP_ALL:   strb.zapAll    = 1'b1;
        CMD_FAULT_ACK: strb.faultDone = 1'b1;
        CMD_HARD_RST:  strb.hardRst   = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xlat_ctrl_dp.sv
module xlat_ctrl_dp
  import xlat_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int MASTER_W   = 5,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_IRQ    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strb,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic                walkBusy,
  input  logic                replayEmpty,
  input  logic                faultPulse,
  input  logic [DATA_W-1:0]   faultAddr,
  input  logic                faultIsWrite,
  input  logic [MASTER_W-1:0] faultMaster,
  input  logic                busErrPulse,
  output logic                irq,
  output logic                pagingOn,
  output logic                stallOn,
  output logic                zapAll,
  output logic                zapLine,
  output logic [DATA_W-1:0]   zapLineAddr,
  output logic [DATA_W-1:0]   gateCfg
);
  localparam int MASTER_LSB = 6;
  localparam logic [DATA_W-1:0] PAGE_KEEP =
    {{(DATA_W-PAGE_SHIFT){1'b1}}, {PAGE_SHIFT{1'b0}}};

  logic [DATA_W-1:0]   baseQ, faultAddrQ, gateQ, zapAddrQ, statusWord;
  logic                pagingEn, stallActive, faultActive, faultWriteQ;
  logic [MASTER_W-1:0] masterQ;
  logic [NUM_IRQ-1:0]  rawIrq, maskQ, evtVec, maskedIrq;
  logic                zapAllQ, zapLineQ;
  logic                faultTake;

  assign faultTake = faultPulse && !faultActive;
  assign evtVec    = NUM_IRQ'({busErrPulse, faultPulse});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0; pagingEn <= 1'b0; stallActive <= 1'b0;
      faultActive <= 1'b0; faultWriteQ <= 1'b0; masterQ <= '0;
      faultAddrQ <= '0; maskQ <= '0; gateQ <= '0;
    end else if (strb.hardRst) begin
      baseQ <= '0; pagingEn <= 1'b0; stallActive <= 1'b0;
      faultActive <= 1'b0; faultWriteQ <= 1'b0; masterQ <= '0;
      faultAddrQ <= '0; maskQ <= '0; gateQ <= '0;
    end else begin
      if (strb.wrBase) baseQ <= busWrData & PAGE_KEEP;
      if (strb.pageOn) pagingEn <= 1'b1;
      else if (strb.pageOff) pagingEn <= 1'b0;
      if (strb.stallOn && pagingEn && !faultActive) stallActive <= 1'b1;
      else if (strb.stallOff) stallActive <= 1'b0;
      if (faultTake) begin
        faultActive <= 1'b1;
        faultAddrQ  <= faultAddr;
        faultWriteQ <= faultIsWrite;
        masterQ     <= faultMaster;
      end else if (strb.faultDone) begin
        faultActive <= 1'b0;
      end
      if (strb.wrMask) maskQ <= busWrData[NUM_IRQ-1:0];
      if (strb.wrGate) gateQ <= busWrData;
    end
  end

  // one pending flop per interrupt cause; a new event beats a clear
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_pend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rawIrq[i] <= 1'b0;
      else if (strb.hardRst) rawIrq[i] <= 1'b0;
      else if (evtVec[i]) rawIrq[i] <= 1'b1;
      else if (strb.wrClear && busWrData[i]) rawIrq[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zapAllQ <= 1'b0; zapLineQ <= 1'b0; zapAddrQ <= '0;
    end else begin
      zapAllQ  <= strb.zapAll;
      zapLineQ <= strb.zapOne;
      if (strb.zapOne) zapAddrQ <= busWrData & PAGE_KEEP;
    end
  end

  assign maskedIrq = rawIrq & maskQ;

  always_comb begin
    statusWord = '0;
    statusWord[0] = pagingEn;
    statusWord[1] = faultActive;
    statusWord[2] = stallActive;
    statusWord[3] = !walkBusy && !faultActive;
    statusWord[4] = replayEmpty;
    statusWord[5] = faultWriteQ;
    statusWord[MASTER_LSB +: MASTER_W] = masterQ;
    statusWord[DATA_W-1] = !stallActive;
  end

  always_comb begin
    rdData = '0;
    case (busAddr)
      ADDR_W'(OFS_BASE):   rdData = baseQ;
      ADDR_W'(OFS_STATUS): rdData = statusWord;
      ADDR_W'(OFS_FADDR):  rdData = faultAddrQ;
      ADDR_W'(OFS_RAW):    rdData = DATA_W'(rawIrq);
      ADDR_W'(OFS_MASK):   rdData = DATA_W'(maskQ);
      ADDR_W'(OFS_MSKD):   rdData = DATA_W'(maskedIrq);
      ADDR_W'(OFS_GATE):   rdData = gateQ;
      default:             rdData = '0;
    endcase
  end

  assign irq         = |maskedIrq;
  assign pagingOn    = pagingEn;
  assign stallOn     = stallActive;
  assign zapAll      = zapAllQ;
  assign zapLine     = zapLineQ;
  assign zapLineAddr = zapAddrQ;
  assign gateCfg     = gateQ;

  assert_base_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBase |=> baseQ == ($past(busWrData) & PAGE_KEEP));
  assert_paging_on_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.pageOn |=> pagingEn);
  assert_stall_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallActive) |-> ($past(pagingEn) && !$past(faultActive)));
  assert_fault_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.faultDone && faultActive) |=> !faultActive);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrClear && !faultPulse && !busErrPulse)
      |=> ((rawIrq & $past(busWrData[NUM_IRQ-1:0])) == '0));
  assert_zap_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    zapAllQ |=> !zapAllQ || $past(strb.zapAll));
  assert_hard_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.hardRst |=> (baseQ == '0 && rawIrq == '0 && !pagingEn && !stallActive));
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int MASTER_W   = 5,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_IRQ    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic                walkBusy,
  input  logic                replayEmpty,
  input  logic                faultPulse,
  input  logic [DATA_W-1:0]   faultAddr,
  input  logic                faultIsWrite,
  input  logic [MASTER_W-1:0] faultMaster,
  input  logic                busErrPulse,
  output logic                irq,
  output logic                pagingOn,
  output logic                stallOn,
  output logic                zapAll,
  output logic                zapLine,
  output logic [DATA_W-1:0]   zapLineAddr,
  output logic [DATA_W-1:0]   gateCfg
);
  ctlStrobe_t strb;

  xlat_ctrl_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .strb(strb)
  );

  xlat_ctrl_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASTER_W(MASTER_W),
    .PAGE_SHIFT(PAGE_SHIFT), .NUM_IRQ(NUM_IRQ)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWrData(busWrData), .rdData(rdData), .walkBusy(walkBusy),
    .replayEmpty(replayEmpty), .faultPulse(faultPulse), .faultAddr(faultAddr),
    .faultIsWrite(faultIsWrite), .faultMaster(faultMaster),
    .busErrPulse(busErrPulse), .irq(irq), .pagingOn(pagingOn),
    .stallOn(stallOn), .zapAll(zapAll), .zapLine(zapLine),
    .zapLineAddr(zapLineAddr), .gateCfg(gateCfg)
  );
endmodule

// File: tb/sim_xlat_ctrl.sv
`timescale 1ns/1ps
module sim_xlat_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] rdData;
  logic        walkBusy = 1'b0;
  logic        replayEmpty = 1'b1;
  logic        faultPulse = 1'b0;
  logic [31:0] faultAddr = '0;
  logic        faultIsWrite = 1'b0;
  logic [4:0]  faultMaster = '0;
  logic        busErrPulse = 1'b0;
  logic        irq, pagingOn, stallOn, zapAll, zapLine;
  logic [31:0] zapLineAddr, gateCfg;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  xlat_ctrl u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .rdData(rdData), .walkBusy(walkBusy),
    .replayEmpty(replayEmpty), .faultPulse(faultPulse), .faultAddr(faultAddr),
    .faultIsWrite(faultIsWrite), .faultMaster(faultMaster),
    .busErrPulse(busErrPulse), .irq(irq), .pagingOn(pagingOn),
    .stallOn(stallOn), .zapAll(zapAll), .zapLine(zapLine),
    .zapLineAddr(zapLineAddr), .gateCfg(gateCfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic fault(input logic [31:0] a, input logic w, input logic [4:0] m);
    @(negedge clk);
    faultPulse = 1'b1; faultAddr = a; faultIsWrite = w; faultMaster = m;
    @(negedge clk);
    faultPulse = 1'b0;
  endtask

  task automatic busErr();
    @(negedge clk);
    busErrPulse = 1'b1;
    @(negedge clk);
    busErrPulse = 1'b0;
  endtask

  task automatic tReset();
    logic [31:0] v;
    rd(6'h04, v); chk("R1 status", v, 32'h8000_0018);
    rd(6'h00, v); chk("R1 base", v, 32'h0);
    rd(6'h1C, v); chk("R1 mask", v, 32'h0);
    rd(6'h14, v); chk("R1 raw", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic tBase();
    logic [31:0] v;
    wr(6'h00, 32'hCAFE_BABE); rd(6'h00, v); chk("R2 base", v, 32'hCAFE_B000);
    wr(6'h00, 32'h0000_0FFF); rd(6'h00, v); chk("R2 low bits", v, 32'h0);
  endtask

  task automatic tPaging();
    logic [31:0] v;
    wr(6'h08, 32'd0); rd(6'h04, v);
    chk("R3 on bit0", {31'b0, v[0]}, 32'h1);
    chk("R3 pagingOn", {31'b0, pagingOn}, 32'h1);
    wr(6'h08, 32'd7); rd(6'h04, v);
    chk("R12 code7 ignored", v, 32'h8000_0019);
    wr(6'h08, 32'h0000_0101); rd(6'h04, v);
    chk("R12 high bits ignored", {31'b0, v[0]}, 32'h1);
    wr(6'h08, 32'd1); rd(6'h04, v);
    chk("R3 off bit0", {31'b0, v[0]}, 32'h0);
  endtask

  task automatic tStall();
    logic [31:0] v;
    wr(6'h08, 32'd2); rd(6'h04, v);
    chk("R4 refused paging off", v, 32'h8000_0018);
    wr(6'h08, 32'd0); wr(6'h08, 32'd2); rd(6'h04, v);
    chk("R4 stall on", v, 32'h0000_001D);
    chk("R4 stallOn", {31'b0, stallOn}, 32'h1);
    wr(6'h08, 32'd3); rd(6'h04, v);
    chk("R4 stall off", v, 32'h8000_0019);
  endtask

  task automatic tFault();
    logic [31:0] v;
    walkBusy = 1'b1; rd(6'h04, v);
    chk("R11 busy not idle", {31'b0, v[3]}, 32'h0);
    walkBusy = 1'b0;
    fault(32'h1234_5678, 1'b1, 5'h15);
    rd(6'h04, v); chk("R5 status", v, 32'h8000_0573);
    rd(6'h0C, v); chk("R5 addr", v, 32'h1234_5678);
    rd(6'h14, v); chk("R5 raw", v, 32'h1);
    fault(32'hDEAD_0000, 1'b0, 5'h02);
    rd(6'h0C, v); chk("R5 no overwrite", v, 32'h1234_5678);
    wr(6'h08, 32'd2); rd(6'h04, v);
    chk("R4 refused during fault", {v[31], 28'b0, v[2:0]}, 32'h8000_0003);
    wr(6'h08, 32'd5); rd(6'h04, v);
    chk("R6 fault cleared", {28'b0, v[3:0]}, 32'h9);
    chk("R11 idle after ack", {31'b0, v[3]}, 32'h1);
  endtask

  task automatic tIrq();
    logic [31:0] v;
    chk("R7 masked off irq", {31'b0, irq}, 32'h0);
    wr(6'h1C, 32'h3);
    rd(6'h1C, v); chk("R7 mask rb", v, 32'h3);
    rd(6'h20, v); chk("R7 masked", v, 32'h1);
    chk("R7 irq", {31'b0, irq}, 32'h1);
    busErr();
    rd(6'h14, v); chk("R7 buserr raw", v, 32'h3);
    wr(6'h18, 32'h1);
    rd(6'h14, v); chk("R8 clear bit0", v, 32'h2);
    wr(6'h1C, 32'h1);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    rd(6'h20, v); chk("R7 masked zero", v, 32'h0);
    wr(6'h18, 32'h2);
    rd(6'h14, v); chk("R8 clear bit1", v, 32'h0);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 6'h18; busWrData = 32'h2; busErrPulse = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busErrPulse = 1'b0;
    rd(6'h14, v); chk("R8 event wins", v, 32'h2);
    wr(6'h18, 32'h3);
  endtask

  task automatic tZap();
    wr(6'h08, 32'd4);
    chk("R9 zapAll", {31'b0, zapAll}, 32'h1);
    chk("R9 no zapLine", {31'b0, zapLine}, 32'h0);
    @(negedge clk);
    chk("R9 zapAll one cycle", {31'b0, zapAll}, 32'h0);
    wr(6'h10, 32'hABCD_E123);
    chk("R9 zapLine", {31'b0, zapLine}, 32'h1);
    chk("R9 zapLineAddr", zapLineAddr, 32'hABCD_E000);
    @(negedge clk);
    chk("R9 zapLine one cycle", {31'b0, zapLine}, 32'h0);
  endtask

  task automatic tGate();
    logic [31:0] v;
    wr(6'h24, 32'h0000_005A);
    rd(6'h24, v); chk("R12 gate rb", v, 32'h5A);
    chk("R12 gateCfg", gateCfg, 32'h5A);
  endtask

  task automatic tHard();
    logic [31:0] v;
    wr(6'h00, 32'h1111_1000);
    wr(6'h08, 32'd0); wr(6'h08, 32'd2);
    wr(6'h1C, 32'h3); busErr();
    chk("R10 pre irq", {31'b0, irq}, 32'h1);
    wr(6'h08, 32'd6);
    rd(6'h00, v); chk("R10 base", v, 32'h0);
    rd(6'h04, v); chk("R10 status", v, 32'h8000_0018);
    rd(6'h1C, v); chk("R10 mask", v, 32'h0);
    rd(6'h14, v); chk("R10 raw", v, 32'h0);
    rd(6'h24, v); chk("R10 gate", v, 32'h0);
    chk("R10 irq", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset(); tBase(); tPaging(); tStall();
    wr(6'h08, 32'd0);
    tFault(); tIrq(); tZap(); tGate(); tHard();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule